// File: doc/BRIEF.md
# Segmented Transparent March RAM Tester

This controller runs a March C- self-test on one quarter of a single-port synchronous RAM and keeps the application data in that quarter. The address space is split into four equal segments by the two top address bits. The highest segment is held back as a shadow store. A start pulse with a segment number from 0 to 2 begins a run, which has three passes. The first pass copies every word of the chosen segment into the same offset of the shadow segment and reads each copy back. The second pass runs the March elements over the segment. The third pass copies the shadow back into the segment and reads back every restored word.

The block has sole use of the RAM port while it is busy. When a run ends it pulses `done`. At that point `pass` or `fail` is valid, and `fail_addr` gives the full RAM address of the first read whose value was wrong. A select value of 3 would point at the shadow segment itself, so it is refused and a flag is raised. A copy that fails its check ends the run at once. The segment has not been written yet at that point, so its data is still intact. A failure during the March pass still runs the full restore, so the application data returns.

Top module: `tmt_march_shadow`

## Requirements
- R1: After reset, `busy`, `done`, `pass`, `fail` and `sel_err` are low and `mem_en` is low. `mem_en` stays low whenever `busy` is low.
- R2: A `start` pulse while idle with `seg_sel` in 0..2 makes `busy` rise on the next cycle. Segment k is the address range whose two top address bits equal k, and the shadow is the range whose top bits are 2'b11.
- R3: A `start` while idle with `seg_sel` = 3 raises `sel_err` on the next cycle. No RAM access follows and no `done` is produced. The next accepted start clears `sel_err`.
- R4: A `start` while `busy` is high is ignored. The current run finishes with a single `done` and its own segment.
- R5: Before any write to the segment under test, each segment word is written to the shadow at the same offset and then read back and compared.
- R6: The March pass writes only all-zero or all-one words, in this order: up w0; up r0,w1; up r1,w0; down r0,w1; down r1,w0; up r0.
- R7: Every compare uses the RAM read data of the cycle after the read was issued.
- R8: A March read mismatch sets `fail` and stops the March pass. `fail_addr` becomes the address of that read, and the full restore still runs, so the segment ends with its original contents.
- R9: A mismatch while checking the copy ends the run with `done` and `fail`. `fail_addr` holds the shadow address read, and the segment under test is never written.
- R10: A run with no mismatch ends with a one-cycle `done`, `pass` high and `fail` low. The segment holds its original data and the shadow holds a copy of it. `pass` and `fail` are never high together.
- R11: During a run, writes go only to the segment under test or to the shadow. The other segments are unchanged.
- R12: A mismatch during restore sets `fail`, and `fail_addr` changes only if no earlier failure was recorded. The restore covers every word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, sampled while idle |
| seg_sel | input | 2 | Segment to test (0..2; 3 is refused) |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable (read when low) |
| mem_addr | output | AW | RAM word address |
| mem_wdata | output | DW | RAM write data |
| mem_rdata | input | DW | RAM read data, one cycle after a read |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Last run found no mismatch |
| fail | output | 1 | A mismatch has been seen in the current or last run |
| sel_err | output | 1 | Last start was refused (select 3) |
| fail_addr | output | AW | Address of the first mismatching read |

## Verification
The assertions assume the RAM is a true single-port device: `mem_rdata` carries the word at the address read one cycle earlier and has no other delay. They also assume the stored contents change only through this port while `busy` is high. The bench's RAM model follows those rules. It places static stuck-at bits only between runs, and it fills memory before a start, never during one. `start` is driven on the falling edge for exactly one cycle, except for the deliberate extra pulse that checks a start is ignored while busy.

// File: rtl/tmt_pkg.sv
package tmt_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SAVE    = 2'd1,
    PH_MARCH   = 2'd2,
    PH_RESTORE = 2'd3
  } phase_t;

  // element index 0..5 of March C-
  localparam logic [2:0] ELEM_LAST = 3'd5;

  function automatic logic elem_reads(input logic [2:0] e);
    return e != 3'd0;
  endfunction

  function automatic logic elem_writes(input logic [2:0] e);
    return e != ELEM_LAST;
  endfunction

  // background bit expected on the read of element e
  function automatic logic elem_rd_bit(input logic [2:0] e);
    return (e == 3'd2) || (e == 3'd4);
  endfunction

  // background bit written by element e
  function automatic logic elem_wr_bit(input logic [2:0] e);
    return (e == 3'd1) || (e == 3'd3);
  endfunction

  function automatic logic elem_down(input logic [2:0] e);
    return (e == 3'd3) || (e == 3'd4);
  endfunction

endpackage

// File: rtl/tmt_addr_gen.sv
module tmt_addr_gen #(
  parameter int OW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          load_down,
  input  logic          step,
  output logic [OW-1:0] offs,
  output logic          at_last
);
  localparam logic [OW-1:0] OFFS_MAX = {OW{1'b1}};

  logic dir_down;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offs     <= '0;
      dir_down <= 1'b0;
    end else if (load) begin
      dir_down <= load_down;
      offs     <= load_down ? OFFS_MAX : '0;
    end else if (step) begin
      offs <= dir_down ? offs - 1'b1 : offs + 1'b1;
    end
  end

  assign at_last = dir_down ? (offs == '0) : (offs == OFFS_MAX);

endmodule

// File: rtl/tmt_rd_track.sv
module tmt_rd_track #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [AW-1:0] issue_addr,
  input  logic [DW-1:0] issue_exp,
  input  logic [DW-1:0] rdata,
  output logic          valid,
  output logic          mismatch,
  output logic [AW-1:0] addr
);
  logic [DW-1:0] exp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      addr  <= '0;
      exp_q <= '0;
    end else begin
      valid <= issue;
      if (issue) begin
        addr  <= issue_addr;
        exp_q <= issue_exp;
      end
    end
  end

  assign mismatch = valid && (rdata != exp_q);

endmodule

// File: rtl/tmt_march_shadow.sv
module tmt_march_shadow #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    seg_sel,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic          sel_err,
  output logic [AW-1:0] fail_addr
);
  import tmt_pkg::*;

  localparam int OW = AW - 2;
  localparam logic [1:0] SHADOW_SEL = 2'b11;

  phase_t        phase;
  logic [1:0]    sel_q;
  logic [1:0]    step;
  logic [2:0]    elem;
  logic [DW-1:0] hold;
  logic          fail_q, pass_q, done_q, sel_err_q;
  logic [AW-1:0] fail_addr_q;

  logic          ag_load, ag_down, ag_step, at_last;
  logic [OW-1:0] offs;
  logic          trk_issue, trk_valid, trk_mis;
  logic [DW-1:0] trk_exp;
  logic [AW-1:0] trk_addr;

  // named internal events
  logic          idle, accept, reject, copy_fail, march_fail, march_adv;
  logic [AW-1:0] seg_addr, shd_addr, src_addr, dst_addr;
  logic [DW-1:0] bg_rd, bg_wr;

  assign idle      = (phase == PH_IDLE);
  assign accept    = idle && start && (seg_sel != SHADOW_SEL);
  assign reject    = idle && start && (seg_sel == SHADOW_SEL);
  assign seg_addr  = {sel_q, offs};
  assign shd_addr  = {SHADOW_SEL, offs};
  assign src_addr  = (phase == PH_SAVE) ? seg_addr : shd_addr;
  assign dst_addr  = (phase == PH_SAVE) ? shd_addr : seg_addr;
  assign bg_rd     = {DW{elem_rd_bit(elem)}};
  assign bg_wr     = {DW{elem_wr_bit(elem)}};
  assign copy_fail  = (phase == PH_SAVE) && (step == 2'd3) && trk_mis;
  assign march_fail = (phase == PH_MARCH) && (step == 2'd1) && trk_mis;
  assign march_adv  = (phase == PH_MARCH) &&
                      (((step == 2'd0) && !elem_reads(elem)) ||
                       ((step == 2'd1) && !trk_mis));

  tmt_addr_gen #(.OW(OW)) u_ag (
    .clk(clk), .rst_n(rst_n), .load(ag_load), .load_down(ag_down),
    .step(ag_step), .offs(offs), .at_last(at_last)
  );

  tmt_rd_track #(.AW(AW), .DW(DW)) u_trk (
    .clk(clk), .rst_n(rst_n), .issue(trk_issue), .issue_addr(mem_addr),
    .issue_exp(trk_exp), .rdata(mem_rdata), .valid(trk_valid),
    .mismatch(trk_mis), .addr(trk_addr)
  );

  // RAM port and address-generator control
  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = seg_addr;
    mem_wdata = '0;
    trk_issue = 1'b0;
    trk_exp   = '0;
    ag_load   = 1'b0;
    ag_down   = 1'b0;
    ag_step   = 1'b0;
    unique case (phase)
      PH_IDLE: ag_load = accept;
      PH_SAVE, PH_RESTORE: begin
        unique case (step)
          2'd0: begin
            mem_en   = 1'b1;
            mem_addr = src_addr;
          end
          2'd1: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = dst_addr;
            mem_wdata = mem_rdata;
          end
          2'd2: begin
            mem_en    = 1'b1;
            mem_addr  = dst_addr;
            trk_issue = 1'b1;
            trk_exp   = hold;
          end
          default: begin
            if (!copy_fail) begin
              if (!at_last)               ag_step = 1'b1;
              else if (phase == PH_SAVE)  ag_load = 1'b1;
            end
          end
        endcase
      end
      PH_MARCH: begin
        if (step == 2'd0) begin
          mem_en = 1'b1;
          if (elem_reads(elem)) begin
            trk_issue = 1'b1;
            trk_exp   = bg_rd;
          end else begin
            mem_we    = 1'b1;
            mem_wdata = bg_wr;
          end
        end else if (!trk_mis && elem_writes(elem)) begin
          mem_en    = 1'b1;
          mem_we    = 1'b1;
          mem_wdata = bg_wr;
        end
        if (march_fail) begin
          ag_load = 1'b1;
        end else if (march_adv) begin
          if (!at_last) begin
            ag_step = 1'b1;
          end else begin
            ag_load = 1'b1;
            ag_down = (elem == ELEM_LAST) ? 1'b0 : elem_down(elem + 3'd1);
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      sel_q       <= '0;
      step        <= '0;
      elem        <= '0;
      hold        <= '0;
      fail_q      <= 1'b0;
      pass_q      <= 1'b0;
      done_q      <= 1'b0;
      sel_err_q   <= 1'b0;
      fail_addr_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (reject) begin
            sel_err_q   <= 1'b1;
            pass_q      <= 1'b0;
            fail_q      <= 1'b0;
            fail_addr_q <= '0;
          end else if (accept) begin
            sel_q       <= seg_sel;
            phase       <= PH_SAVE;
            step        <= '0;
            sel_err_q   <= 1'b0;
            pass_q      <= 1'b0;
            fail_q      <= 1'b0;
            fail_addr_q <= '0;
          end
        end
        PH_SAVE, PH_RESTORE: begin
          step <= step + 2'd1;
          if (step == 2'd1) hold <= mem_rdata;
          if (step == 2'd3) begin
            if (trk_mis && !fail_q) begin
              fail_q      <= 1'b1;
              fail_addr_q <= trk_addr;
            end
            if (copy_fail) begin
              phase  <= PH_IDLE;
              done_q <= 1'b1;
            end else if (at_last) begin
              if (phase == PH_SAVE) begin
                phase <= PH_MARCH;
                elem  <= '0;
              end else begin
                phase  <= PH_IDLE;
                done_q <= 1'b1;
                pass_q <= !(fail_q || trk_mis);
              end
            end
          end
        end
        PH_MARCH: begin
          if (step == 2'd0 && elem_reads(elem)) step <= 2'd1;
          else                                   step <= 2'd0;
          if (march_fail) begin
            fail_q      <= 1'b1;
            fail_addr_q <= trk_addr;
            phase       <= PH_RESTORE;
          end else if (march_adv && at_last) begin
            if (elem == ELEM_LAST) phase <= PH_RESTORE;
            else                   elem  <= elem + 3'd1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy      = !idle;
  assign done      = done_q;
  assign pass      = pass_q;
  assign fail      = fail_q;
  assign sel_err   = sel_err_q;
  assign fail_addr = fail_addr_q;

  // ---------------- assertions ----------------
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en) else $error("idle port activity"); // R1

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && seg_sel != SHADOW_SEL) |=> busy) else $error("start not taken"); // R2

  AST_SEL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && seg_sel == SHADOW_SEL) |=> (sel_err && !busy)) else $error("select 3 taken"); // R3

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> $stable(sel_q)) else $error("start accepted while busy"); // R4

  AST_SAVE_WR_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SAVE && mem_en && mem_we) |-> (mem_addr[AW-1 -: 2] == SHADOW_SEL)) else $error("save wrote outside shadow"); // R5

  AST_MARCH_BG: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_MARCH && mem_en && mem_we) |-> (mem_wdata == '0 || mem_wdata == '1)) else $error("bad background"); // R6

  AST_CMP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    trk_valid |-> $past(mem_en && !mem_we)) else $error("compare without read"); // R7

  AST_MARCH_FAIL_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_MARCH && trk_mis) |=> (phase == PH_RESTORE && fail)) else $error("no restore after fail"); // R8

  AST_COPY_FAIL_END: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SAVE && trk_mis) |=> (done && fail && !busy)) else $error("copy fail not ended"); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done too long"); // R10

  AST_PASS_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail)) else $error("pass with fail"); // R10

  AST_WRITE_CONFINED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> (mem_addr[AW-1 -: 2] == sel_q || mem_addr[AW-1 -: 2] == SHADOW_SEL)) else $error("stray write"); // R11

endmodule

// File: tb/sim_tmt_march_shadow.sv
module sim_tmt_march_shadow;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int WORDS = 1 << AW;
  localparam int SEGW = WORDS / 4;
  localparam int WATCHDOG = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    seg_sel = 2'd0;
  logic          mem_en, mem_we, busy, done, pass, fail, sel_err;
  logic [AW-1:0] mem_addr, fail_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmt_march_shadow #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .seg_sel(seg_sel),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .pass(pass), .fail(fail),
    .sel_err(sel_err), .fail_addr(fail_addr)
  );

  // ---------- RAM model with a static stuck-at fault ----------
  logic [DW-1:0] ram  [WORDS];
  logic [DW-1:0] snap [WORDS];
  logic          flt_on = 1'b0;
  logic [AW-1:0] flt_addr = '0;
  logic [DW-1:0] flt_s0 = '0, flt_s1 = '0;
  logic          fill_go = 1'b0;
  logic [DW-1:0] fill_seed = '0;

  function automatic logic [DW-1:0] pat(input int i, input logic [DW-1:0] s);
    return DW'((i * int'(s)) ^ (i >> 2)) ^ s;
  endfunction

  function automatic logic [DW-1:0] stick(input int a, input logic [DW-1:0] d);
    if (flt_on && a == int'(flt_addr)) return (d & ~flt_s0) | flt_s1;
    return d;
  endfunction

  always @(posedge clk) begin
    if (fill_go) begin
      for (int i = 0; i < WORDS; i++) ram[i] <= stick(i, pat(i, fill_seed));
    end else if (mem_en) begin
      if (mem_we) ram[mem_addr] <= stick(int'(mem_addr), mem_wdata);
      mem_rdata <= ram[mem_addr];
    end
  end

  // ---------- counters and checking ----------
  int n_tests = 0, n_fail = 0;
  int done_cnt = 0, idle_acc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  typedef struct {
    bit            exp_fail;
    logic [AW-1:0] exp_addr;
    bit            chk_shadow;
    int            seg;
    string         req;
  } exp_t;
  exp_t sb[$];

  // monitor: pops expectations as runs complete
  always @(negedge clk) begin
    if (rst_n && !busy && mem_en) idle_acc++;
    if (rst_n && done) begin
      done_cnt++;
      if (sb.size() == 0) begin
        chk(1'b0, "R10", "unexpected done", 1, 0);
      end else begin
        exp_t it;
        int bad;
        it = sb.pop_front();
        chk(pass == !it.exp_fail, it.req, "pass", pass, !it.exp_fail);
        chk(fail == it.exp_fail, it.req, "fail", fail, it.exp_fail);
        if (it.exp_fail)
          chk(fail_addr == it.exp_addr, it.req, "fail_addr", fail_addr, it.exp_addr);
        bad = 0;
        for (int i = 0; i < 3 * SEGW; i++) if (ram[i] !== snap[i]) bad++;
        chk(bad == 0, "R11 R12", "data words changed", bad, 0);
        if (it.chk_shadow) begin
          bad = 0;
          for (int i = 0; i < SEGW; i++)
            if (ram[3 * SEGW + i] !== ram[it.seg * SEGW + i]) bad++;
          chk(bad == 0, "R5 R10", "shadow copy mismatches", bad, 0);
        end
      end
    end
  end

  task automatic fill(input logic [DW-1:0] seed);
    @(negedge clk);
    fill_seed = seed;
    fill_go   = 1'b1;
    @(negedge clk);
    fill_go   = 1'b0;
  endtask

  task automatic run(input int seg, input bit efail, input int eaddr,
                     input bit shd, input string req);
    exp_t it;
    int c;
    it.exp_fail = efail; it.exp_addr = AW'(eaddr); it.chk_shadow = shd;
    it.seg = seg; it.req = req;
    sb.push_back(it);
    for (int i = 0; i < WORDS; i++) snap[i] = ram[i];
    c = done_cnt;
    @(negedge clk);
    start = 1'b1; seg_sel = 2'(seg);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    while (done_cnt == c) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(done_cnt == c + 1, "R4 R10", "done count", done_cnt - c, 1);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired: actual %0d expected 0 hang", WATCHDOG);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0,    "R1", "busy", busy, 0);
    chk(done == 0,    "R1", "done", done, 0);
    chk(pass == 0,    "R1", "pass", pass, 0);
    chk(fail == 0,    "R1", "fail", fail, 0);
    chk(sel_err == 0, "R1", "sel_err", sel_err, 0);
    chk(mem_en == 0,  "R1", "mem_en", mem_en, 0);

    // R2 R6 R10: clean runs on each data segment
    fill(8'h5A);
    run(0, 0, 0, 1, "R10");
    run(1, 0, 0, 1, "R10");
    fill(8'hC3);
    run(2, 0, 0, 1, "R6");

    // R3: select 3 refused
    for (int i = 0; i < WORDS; i++) snap[i] = ram[i];
    c = done_cnt; idle_acc = 0;
    @(negedge clk); start = 1'b1; seg_sel = 2'd3;
    @(negedge clk); start = 1'b0;
    chk(sel_err == 1, "R3", "sel_err", sel_err, 1);
    chk(busy == 0,    "R3", "busy", busy, 0);
    repeat (20) @(negedge clk);
    chk(done_cnt == c, "R3", "done after refuse", done_cnt - c, 0);
    chk(idle_acc == 0, "R3", "RAM accesses", idle_acc, 0);
    begin
      int bad = 0;
      for (int i = 0; i < WORDS; i++) if (ram[i] !== snap[i]) bad++;
      chk(bad == 0, "R3", "words changed", bad, 0);
    end
    @(negedge clk); start = 1'b1; seg_sel = 2'd1;
    sb.push_back('{1'b0, '0, 1'b1, 1, "R3"});
    c = done_cnt;
    @(negedge clk); start = 1'b0;
    chk(sel_err == 0, "R3", "sel_err cleared", sel_err, 0);
    while (done_cnt == c) @(negedge clk);

    // R4: start while busy is ignored
    fill(8'h37);
    begin
      exp_t it;
      it.exp_fail = 0; it.exp_addr = '0; it.chk_shadow = 1; it.seg = 0; it.req = "R4";
      sb.push_back(it);
      for (int i = 0; i < WORDS; i++) snap[i] = ram[i];
      c = done_cnt;
      @(negedge clk); start = 1'b1; seg_sel = 2'd0;
      @(negedge clk); start = 1'b0;
      repeat (100) @(negedge clk);
      start = 1'b1; seg_sel = 2'd2;
      @(negedge clk); start = 1'b0;
      while (done_cnt == c) @(negedge clk);
      repeat (30) @(negedge clk);
      chk(done_cnt == c + 1, "R4", "done count", done_cnt - c, 1);
      chk(busy == 0, "R4", "busy after run", busy, 0);
    end

    // R8: stuck-at-1 bit0 at segment 1 offset 5 -> first r0 read fails
    flt_on = 1; flt_addr = AW'(SEGW + 5); flt_s1 = 8'h01; flt_s0 = 8'h00;
    fill(8'h5A);
    run(1, 1, SEGW + 5, 0, "R8");

    // R8 R12: stuck-at-0 bit7 at segment 2 offset 10 -> first r1 read fails
    flt_addr = AW'(2 * SEGW + 10); flt_s1 = 8'h00; flt_s0 = 8'h80;
    fill(8'h21);
    run(2, 1, 2 * SEGW + 10, 0, "R8");

    // R9: stuck bit in shadow offset 3 where segment 0 word has a zero
    flt_on = 0;
    fill(8'h5A);
    @(negedge clk);
    begin
      logic [DW-1:0] z;
      z = ~ram[3];
      flt_s1 = z & (~z + 1'b1);
    end
    flt_s0 = 8'h00; flt_addr = AW'(3 * SEGW + 3); flt_on = 1;
    run(0, 1, 3 * SEGW + 3, 0, "R9");

    // clean run after a failure clears fail (R10)
    flt_on = 0;
    fill(8'h99);
    run(0, 0, 0, 1, "R10");

    repeat (5) @(negedge clk);
    chk(sb.size() == 0, "R10", "pending expectations", sb.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule